// File: doc/BRIEF.md
# Bit-Vector Directory Coherence Controller

This block is the home-node directory for a set of memory blocks shared by a group of processors under an invalidation protocol. For every block it keeps a full map of presence bits, one per processor, plus one dirty bit. Together these encode three states. A block with no presence bits and a clear dirty bit is uncached. A block with one or more presence bits and a clear dirty bit is shared. A block with a set dirty bit is held exclusively by the single processor whose presence bit is set.

Processors send read or read-exclusive (write) requests. Where the directory alone can answer, the controller replies on the next cycle with data from the home memory. Otherwise it sends invalidations to the sharers or a recall to the owner on a per-processor command vector. It counts the acknowledgements that come back, and when the last one arrives it updates memory and the directory and answers the requester. Owners that evict a dirty line send a write-back, which updates memory and returns the block to uncached.

One coherence transaction can be outstanding at a time. A request that cannot be taken gets a negative acknowledgement (NACK) one cycle later and is expected to be retried. Home memory is a single-port array with combinational read outside the block.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every block is uncached, and no reply, NACK or command is driven.
- R2: A read of a block that is not dirty is answered on the next cycle with the memory data and rsp_excl=0, and the reader is added to the presence map.
- R3: A read of a block held dirty by another processor produces, on the next cycle, a single command of kind 2 (recall, keep a shared copy) to the owner only. Once the owner's acknowledgement with data is in, the requester gets that data with rsp_excl=0, the data is written to memory, and both processors are then sharers.
- R4: A write to a clean block with sharers other than the requester produces, on the next cycle, a command of kind 1 (invalidate) to exactly those sharers. The exclusive reply (rsp_excl=1, memory data) is withheld until every one of them has acknowledged.
- R5: A write to a block with no other sharers and a clear dirty bit is answered on the next cycle with rsp_excl=1, and the writer becomes the only holder with the dirty bit set.
- R6: A write to a block held dirty by another processor produces a command of kind 3 (recall and invalidate) to the owner only. After the owner's acknowledgement the requester gets the recalled data with rsp_excl=1, memory takes that data, and the requester is the sole exclusive holder.
- R7: A request from the processor that already holds the block dirty is answered on the next cycle with rsp_excl=1, and no command is sent.
- R8: A write-back from the exclusive owner of a block writes its data to memory and makes the block uncached.
- R9: A write-back from a processor that is not the dirty owner, or to a block that is not dirty, is ignored: memory and directory keep their values.
- R10: While a transaction is outstanding, every request to its block is NACKed on the next cycle, and so is any request elsewhere that would need commands. Requests elsewhere that need no commands are still served.
- R11: Acknowledgements from processors that were not sent a command are ignored and do not shorten the wait. The reply comes in the second cycle after the last expected acknowledgement is sampled.
- R12: The memory port goes first to a taken write-back, then to a completing transaction, then to a new request. A request that needs memory but loses the port is NACKed, and so is a request to the same block as a write-back presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = read-exclusive, 0 = read |
| req_src | input | PW | Requesting processor |
| req_blk | input | BW | Requested block |
| wb_valid | input | 1 | Eviction write-back present |
| wb_src | input | PW | Processor writing back |
| wb_blk | input | BW | Block written back |
| wb_data | input | DW | Write-back data |
| ack_valid | input | NPROC | Per-processor acknowledgement of a command |
| ack_data | input | DW | Data returned with a recall acknowledgement |
| mem_addr | output | BW | Home memory address |
| mem_we | output | 1 | Home memory write enable |
| mem_wdata | output | DW | Home memory write data |
| mem_rdata | input | DW | Home memory read data (combinational) |
| rsp_valid | output | 1 | Data reply to a requester |
| rsp_dst | output | PW | Processor receiving the reply |
| rsp_blk | output | BW | Block of the reply |
| rsp_excl | output | 1 | 1 = exclusive grant, 0 = shared |
| rsp_data | output | DW | Reply data |
| nack_valid | output | 1 | Request refused |
| nack_dst | output | PW | Processor whose request was refused |
| nack_blk | output | BW | Block of the refused request |
| cmd_valid | output | NPROC | Processors addressed by a coherence command |
| cmd_kind | output | 2 | 1 invalidate, 2 recall keep shared, 3 recall and invalidate |
| cmd_blk | output | BW | Block the command refers to |

## Verification
The bench goes after the timing of the withheld reply. A design that answers when the first invalidation acknowledgement arrives, or that counts an acknowledgement from a processor it never addressed, replies early with the wrong cycle. It also targets the ownership edges: owner recall on a read must leave both processors as sharers, and a wrong map shows up later as a missing invalidation. A request from the current owner must send no command. Write-backs from non-owners must leave memory untouched. Finally it targets same-cycle collisions on the memory port and on the busy block, where a design with the wrong priority either serves a request with stale data or loses a write-back. A long mixed phase on four contended blocks with stray acknowledgements then checks these cases against each other.

// File: rtl/dir_pkg.sv
package dir_pkg;

   // coherence command codes placed on cmd_kind
   localparam logic [1:0] CMD_NONE    = 2'd0;
   localparam logic [1:0] CMD_INV     = 2'd1;
   localparam logic [1:0] CMD_RCL_SH  = 2'd2;
   localparam logic [1:0] CMD_RCL_INV = 2'd3;

   // what the directory decides to do with one request
   typedef enum logic [2:0] {
      ACT_FILL_SH  = 3'd0,  // reply shared from memory
      ACT_FILL_EX  = 3'd1,  // reply exclusive, no messages
      ACT_INVAL    = 3'd2,  // invalidate sharers, then exclusive
      ACT_RCL_SH   = 3'd3,  // recall owner to shared
      ACT_RCL_INV  = 3'd4   // recall and invalidate owner
   } act_e;

   function automatic logic act_needs_msg(act_e a);
      return (a == ACT_INVAL) || (a == ACT_RCL_SH) || (a == ACT_RCL_INV);
   endfunction

   function automatic logic act_is_recall(act_e a);
      return (a == ACT_RCL_SH) || (a == ACT_RCL_INV);
   endfunction

   function automatic logic [1:0] act_cmd(act_e a);
      case (a)
         ACT_INVAL:   return CMD_INV;
         ACT_RCL_SH:  return CMD_RCL_SH;
         ACT_RCL_INV: return CMD_RCL_INV;
         default:     return CMD_NONE;
      endcase
   endfunction

endpackage

// File: rtl/dir_store.sv
module dir_store #(
   parameter int NPROC = 4,
   parameter int NBLK  = 16,
   parameter int BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BW-1:0]    ra_blk,
   output logic [NPROC-1:0] ra_pres,
   output logic             ra_dirty,
   input  logic [BW-1:0]    rb_blk,
   output logic [NPROC-1:0] rb_pres,
   output logic             rb_dirty,
   input  logic             we,
   input  logic [BW-1:0]    w_blk,
   input  logic [NPROC-1:0] w_pres,
   input  logic             w_dirty
);

   logic [NPROC-1:0] pres_a  [NBLK];
   logic             dirty_a [NBLK];

   for (genvar b = 0; b < NBLK; b++) begin : g_ent
      logic [NPROC-1:0] p_q;
      logic             d_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= '0;
            d_q <= 1'b0;
         end else if (we && (w_blk == BW'(b))) begin
            p_q <= w_pres;
            d_q <= w_dirty;
         end
      end
      assign pres_a[b]  = p_q;
      assign dirty_a[b] = d_q;
   end

   assign ra_pres  = pres_a[ra_blk];
   assign ra_dirty = dirty_a[ra_blk];
   assign rb_pres  = pres_a[rb_blk];
   assign rb_dirty = dirty_a[rb_blk];

endmodule

// File: rtl/dir_decide.sv
module dir_decide
   import dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int PW    = (NPROC > 1) ? $clog2(NPROC) : 1
) (
   input  logic [NPROC-1:0] pres,
   input  logic             dirty,
   input  logic [PW-1:0]    src,
   input  logic             is_write,
   output act_e             act,
   output logic [NPROC-1:0] target,
   output logic [NPROC-1:0] new_pres,
   output logic             new_dirty
);

   logic [NPROC-1:0] src_bit;
   logic [NPROC-1:0] others;

   assign src_bit = {{(NPROC-1){1'b0}}, 1'b1} << src;
   assign others  = pres & ~src_bit;

   always_comb begin
      act       = ACT_FILL_SH;
      target    = '0;
      new_pres  = pres;
      new_dirty = dirty;
      if (dirty && ((pres & src_bit) != '0)) begin
         // requester already owns the line
         act       = ACT_FILL_EX;
         new_pres  = pres;
         new_dirty = 1'b1;
      end else if (dirty) begin
         act    = is_write ? ACT_RCL_INV : ACT_RCL_SH;
         target = pres;
      end else if (!is_write) begin
         act       = ACT_FILL_SH;
         new_pres  = pres | src_bit;
         new_dirty = 1'b0;
      end else if (others == '0) begin
         act       = ACT_FILL_EX;
         new_pres  = src_bit;
         new_dirty = 1'b1;
      end else begin
         act    = ACT_INVAL;
         target = others;
      end
   end

endmodule

// File: rtl/dir_tracker.sv
module dir_tracker
   import dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int NBLK  = 16,
   parameter int DW    = 32,
   parameter int PW    = (NPROC > 1) ? $clog2(NPROC) : 1,
   parameter int BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [BW-1:0]    start_blk,
   input  logic [PW-1:0]    start_src,
   input  act_e             start_act,
   input  logic [NPROC-1:0] start_mask,
   input  logic             finish,
   input  logic [NPROC-1:0] ack_valid,
   input  logic [DW-1:0]    ack_data,
   output logic             busy,
   output logic [BW-1:0]    blk,
   output logic [PW-1:0]    src,
   output act_e             act,
   output logic             pend_zero,
   output logic [NPROC-1:0] owner,
   output logic [DW-1:0]    data
);

   logic [NPROC-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         blk    <= '0;
         src    <= '0;
         act    <= ACT_FILL_SH;
         pend_q <= '0;
         owner  <= '0;
         data   <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         blk    <= start_blk;
         src    <= start_src;
         act    <= start_act;
         pend_q <= start_mask;
         owner  <= start_mask;
         data   <= '0;
      end else if (finish) begin
         busy   <= 1'b0;
         pend_q <= '0;
      end else if (busy) begin
         pend_q <= pend_q & ~ack_valid;
         if (act_is_recall(act) && ((ack_valid & owner & pend_q) != '0))
            data <= ack_data;
      end
   end

   assign pend_zero = (pend_q == '0);

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
   import dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int NBLK  = 16,
   parameter int DW    = 32,
   parameter int PW    = (NPROC > 1) ? $clog2(NPROC) : 1,
   parameter int BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [PW-1:0]    req_src,
   input  logic [BW-1:0]    req_blk,
   input  logic             wb_valid,
   input  logic [PW-1:0]    wb_src,
   input  logic [BW-1:0]    wb_blk,
   input  logic [DW-1:0]    wb_data,
   input  logic [NPROC-1:0] ack_valid,
   input  logic [DW-1:0]    ack_data,
   output logic [BW-1:0]    mem_addr,
   output logic             mem_we,
   output logic [DW-1:0]    mem_wdata,
   input  logic [DW-1:0]    mem_rdata,
   output logic             rsp_valid,
   output logic [PW-1:0]    rsp_dst,
   output logic [BW-1:0]    rsp_blk,
   output logic             rsp_excl,
   output logic [DW-1:0]    rsp_data,
   output logic             nack_valid,
   output logic [PW-1:0]    nack_dst,
   output logic [BW-1:0]    nack_blk,
   output logic [NPROC-1:0] cmd_valid,
   output logic [1:0]       cmd_kind,
   output logic [BW-1:0]    cmd_blk
);

   // elaboration-time parameter checks
   if (NPROC < 2) begin : g_bad_nproc
      $error("dir_ctrl: NPROC must be at least 2");
   end
   if (NBLK < 2) begin : g_bad_nblk
      $error("dir_ctrl: NBLK must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dir_ctrl: DW must be positive");
   end

   // ---------------------------------------------------------------
   // directory lookup and decision
   // ---------------------------------------------------------------
   logic [NPROC-1:0] a_pres, b_pres;
   logic             a_dirty, b_dirty;
   logic             dir_we;
   logic [BW-1:0]    dir_wblk;
   logic [NPROC-1:0] dir_wpres;
   logic             dir_wdirty;

   dir_store #(.NPROC(NPROC), .NBLK(NBLK), .BW(BW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .ra_blk   (req_blk),
      .ra_pres  (a_pres),
      .ra_dirty (a_dirty),
      .rb_blk   (wb_blk),
      .rb_pres  (b_pres),
      .rb_dirty (b_dirty),
      .we       (dir_we),
      .w_blk    (dir_wblk),
      .w_pres   (dir_wpres),
      .w_dirty  (dir_wdirty)
   );

   act_e             req_act;
   logic [NPROC-1:0] req_target;
   logic [NPROC-1:0] req_npres;
   logic             req_ndirty;

   dir_decide #(.NPROC(NPROC), .PW(PW)) u_decide (
      .pres      (a_pres),
      .dirty     (a_dirty),
      .src       (req_src),
      .is_write  (req_write),
      .act       (req_act),
      .target    (req_target),
      .new_pres  (req_npres),
      .new_dirty (req_ndirty)
   );

   // ---------------------------------------------------------------
   // transaction tracker
   // ---------------------------------------------------------------
   logic             trk_busy;
   logic [BW-1:0]    trk_blk;
   logic [PW-1:0]    trk_src;
   act_e             trk_act;
   logic             trk_pend_zero;
   logic [NPROC-1:0] trk_owner;
   logic [DW-1:0]    trk_data;
   logic             req_start;
   logic             finish;

   dir_tracker #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW), .PW(PW), .BW(BW)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (req_start),
      .start_blk  (req_blk),
      .start_src  (req_src),
      .start_act  (req_act),
      .start_mask (req_target),
      .finish     (finish),
      .ack_valid  (ack_valid),
      .ack_data   (ack_data),
      .busy       (trk_busy),
      .blk        (trk_blk),
      .src        (trk_src),
      .act        (trk_act),
      .pend_zero  (trk_pend_zero),
      .owner      (trk_owner),
      .data       (trk_data)
   );

   // ---------------------------------------------------------------
   // arbitration: write-back > completion > new request
   // ---------------------------------------------------------------
   logic wb_hit;
   logic port_taken;
   logic req_needs_msg;
   logic req_nack;
   logic req_fill;
   logic [NPROC-1:0] trk_src_bit;

   assign wb_hit = wb_valid && b_dirty && ((b_pres >> wb_src) & {{(NPROC-1){1'b0}}, 1'b1}) != '0
                   && !(trk_busy && (wb_blk == trk_blk));
   assign finish        = trk_busy && trk_pend_zero && !wb_hit;
   assign port_taken    = wb_hit || finish;
   assign req_needs_msg = act_needs_msg(req_act);

   assign req_nack = req_valid &&
                     ((trk_busy && (req_blk == trk_blk)) ||
                      (wb_valid && (wb_blk == req_blk)) ||
                      (req_needs_msg && trk_busy) ||
                      (!req_needs_msg && port_taken));
   assign req_fill  = req_valid && !req_nack && !req_needs_msg;
   assign req_start = req_valid && !req_nack && req_needs_msg;

   assign trk_src_bit = {{(NPROC-1){1'b0}}, 1'b1} << trk_src;

   // memory port
   always_comb begin
      if (wb_hit) begin
         mem_addr  = wb_blk;
         mem_we    = 1'b1;
         mem_wdata = wb_data;
      end else if (finish) begin
         mem_addr  = trk_blk;
         mem_we    = act_is_recall(trk_act);
         mem_wdata = trk_data;
      end else begin
         mem_addr  = req_blk;
         mem_we    = 1'b0;
         mem_wdata = wb_data;
      end
   end

   // directory write port (one writer per cycle by construction of arbitration)
   always_comb begin
      dir_we     = 1'b0;
      dir_wblk   = req_blk;
      dir_wpres  = req_npres;
      dir_wdirty = req_ndirty;
      if (wb_hit) begin
         dir_we     = 1'b1;
         dir_wblk   = wb_blk;
         dir_wpres  = '0;
         dir_wdirty = 1'b0;
      end else if (finish) begin
         dir_we   = 1'b1;
         dir_wblk = trk_blk;
         if (trk_act == ACT_RCL_SH) begin
            dir_wpres  = trk_owner | trk_src_bit;
            dir_wdirty = 1'b0;
         end else begin
            dir_wpres  = trk_src_bit;
            dir_wdirty = 1'b1;
         end
      end else if (req_fill) begin
         dir_we = 1'b1;
      end
   end

   // ---------------------------------------------------------------
   // registered outputs
   // ---------------------------------------------------------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_dst    <= '0;
         rsp_blk    <= '0;
         rsp_excl   <= 1'b0;
         rsp_data   <= '0;
         nack_valid <= 1'b0;
         nack_dst   <= '0;
         nack_blk   <= '0;
         cmd_valid  <= '0;
         cmd_kind   <= CMD_NONE;
         cmd_blk    <= '0;
      end else begin
         rsp_valid <= finish || req_fill;
         if (finish) begin
            rsp_dst  <= trk_src;
            rsp_blk  <= trk_blk;
            rsp_excl <= (trk_act != ACT_RCL_SH);
            rsp_data <= act_is_recall(trk_act) ? trk_data : mem_rdata;
         end else if (req_fill) begin
            rsp_dst  <= req_src;
            rsp_blk  <= req_blk;
            rsp_excl <= (req_act == ACT_FILL_EX);
            rsp_data <= mem_rdata;
         end

         nack_valid <= req_nack;
         if (req_nack) begin
            nack_dst <= req_src;
            nack_blk <= req_blk;
         end

         cmd_valid <= req_start ? req_target : '0;
         cmd_kind  <= req_start ? act_cmd(req_act) : CMD_NONE;
         if (req_start)
            cmd_blk <= req_blk;
      end
   end

endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
   parameter int NPROC = 4,
   parameter int PW    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             wb_valid,
   input logic             rsp_valid,
   input logic             nack_valid,
   input logic [NPROC-1:0] cmd_valid,
   input logic [1:0]       cmd_kind,
   input logic             mem_we,
   input logic             trk_busy,
   input logic [PW-1:0]    trk_src
);

   // R4: any command carries a non-zero kind
   a_r4_cmd_has_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid != '0) |-> (cmd_kind != 2'd0));

   // R3 / R6: a recall addresses exactly one processor
   a_r3_recall_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_valid != '0) && (cmd_kind != 2'd1)) |-> ($countones(cmd_valid) == 1));

   // R4: the requester never receives its own invalidation
   a_r4_cmd_skips_requester: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid != '0) |-> !cmd_valid[trk_src]);

   // R10: a NACK follows a request of the previous cycle
   a_r10_nack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      nack_valid |-> $past(req_valid));

   // R10: one request never gets both a NACK and commands
   a_r10_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !(nack_valid && (cmd_valid != '0)));

   // R10: commands only go out for a transaction being tracked
   a_r10_cmd_needs_tracker: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid != '0) |-> trk_busy);

   // R11: replies come from a request or from a tracked transaction
   a_r11_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(req_valid) || $past(trk_busy)));

   // R8: memory is written only by a write-back or a completing recall
   a_r8_mem_write_cause: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (wb_valid || trk_busy));

endmodule

bind dir_ctrl dir_ctrl_chk #(.NPROC(NPROC), .PW(PW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .wb_valid   (wb_valid),
   .rsp_valid  (rsp_valid),
   .nack_valid (nack_valid),
   .cmd_valid  (cmd_valid),
   .cmd_kind   (cmd_kind),
   .mem_we     (mem_we),
   .trk_busy   (trk_busy),
   .trk_src    (trk_src)
);

// File: tb/dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module dir_ctrl_tb_top;

   localparam int NP = 4;
   localparam int NB = 16;
   localparam int DW = 32;
   localparam int PW = 2;
   localparam int BW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [PW-1:0] req_src = '0;
   logic [BW-1:0] req_blk = '0;
   logic          wb_valid = 1'b0;
   logic [PW-1:0] wb_src = '0;
   logic [BW-1:0] wb_blk = '0;
   logic [DW-1:0] wb_data = '0;
   logic [NP-1:0] ack_valid = '0;
   logic [DW-1:0] ack_data = '0;
   logic [BW-1:0] mem_addr;
   logic          mem_we;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic          rsp_valid, rsp_excl, nack_valid;
   logic [PW-1:0] rsp_dst, nack_dst;
   logic [BW-1:0] rsp_blk, nack_blk, cmd_blk;
   logic [DW-1:0] rsp_data;
   logic [NP-1:0] cmd_valid;
   logic [1:0]    cmd_kind;

   always #2 clk = ~clk;  // 250 MHz

   dir_ctrl #(.NPROC(NP), .NBLK(NB), .DW(DW)) dut_i (.*);

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   // home memory: combinational read, write on the clock
   logic [DW-1:0] mem [NB];
   assign mem_rdata = mem[mem_addr];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) mem[b] <= 32'hA000_0000 + b;
      end else if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
      end
   end

   // ---------------------------------------------------------------
   // behavioural reference model
   // ---------------------------------------------------------------
   logic [NP-1:0] rp [NB];
   logic          rd [NB];
   logic [DW-1:0] rmem [NB];
   logic          tb_busy;
   logic [BW-1:0] tb_blk;
   logic [PW-1:0] tb_src;
   int            tb_kind;     // 2 inval, 3 recall-shared, 4 recall-inval
   logic [NP-1:0] tb_pend, tb_own;
   logic [DW-1:0] tb_data;
   logic          e_rsp, e_excl, e_nack;
   logic [PW-1:0] e_rdst, e_ndst;
   logic [BW-1:0] e_rblk, e_nblk, e_cblk;
   logic [DW-1:0] e_rdata;
   logic [NP-1:0] e_cmd;
   logic [1:0]    e_kind;

   always @(posedge clk or negedge rst_n) begin : mdl
      logic wbok, fin, nk, msg, st;
      logic [NP-1:0] sb, p, tgt;
      logic d;
      int k;
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin
            rp[b] = '0; rd[b] = 1'b0; rmem[b] = 32'hA000_0000 + b;
         end
         tb_busy = 1'b0; tb_pend = '0; tb_own = '0; tb_data = '0;
         tb_blk = '0; tb_src = '0; tb_kind = 0;
         e_rsp = 0; e_nack = 0; e_cmd = '0; e_kind = '0; e_excl = 0;
         e_rdst = '0; e_ndst = '0; e_rblk = '0; e_nblk = '0; e_cblk = '0; e_rdata = '0;
      end else begin
         e_rsp = 0; e_nack = 0; e_cmd = '0; e_kind = '0;
         st = 0; k = 0; tgt = '0; sb = '0;
         wbok = wb_valid && rd[wb_blk] && rp[wb_blk][wb_src] && !(tb_busy && wb_blk == tb_blk);
         fin  = tb_busy && (tb_pend == '0) && !wbok;
         if (req_valid) begin
            sb = NP'(1) << req_src;
            p = rp[req_blk]; d = rd[req_blk];
            if (d && (p & sb) != '0)       k = 1;
            else if (d) begin               k = req_write ? 4 : 3; tgt = p; end
            else if (!req_write)            k = 0;
            else if ((p & ~sb) == '0)       k = 1;
            else begin                      k = 2; tgt = p & ~sb; end
            msg = (k >= 2);
            nk = (tb_busy && req_blk == tb_blk) || (wb_valid && wb_blk == req_blk) ||
                 (msg && tb_busy) || (!msg && (wbok || fin));
            if (nk) begin
               e_nack = 1; e_ndst = req_src; e_nblk = req_blk;
            end else if (msg) begin
               e_cmd = tgt; e_cblk = req_blk;
               e_kind = (k == 2) ? 2'd1 : (k == 3) ? 2'd2 : 2'd3;
               st = 1;
            end else begin
               e_rsp = 1; e_rdst = req_src; e_rblk = req_blk; e_excl = (k == 1);
               e_rdata = rmem[req_blk];
               if (k == 1) begin rp[req_blk] = d ? p : sb; rd[req_blk] = 1; end
               else begin rp[req_blk] = p | sb; rd[req_blk] = 0; end
            end
         end
         if (wbok) begin
            rmem[wb_blk] = wb_data; rp[wb_blk] = '0; rd[wb_blk] = 0;
         end
         if (fin) begin
            e_rsp = 1; e_rdst = tb_src; e_rblk = tb_blk; e_excl = (tb_kind != 3);
            e_rdata = (tb_kind == 2) ? rmem[tb_blk] : tb_data;
            if (tb_kind != 2) rmem[tb_blk] = tb_data;
            rp[tb_blk] = (tb_kind == 3) ? (tb_own | (NP'(1) << tb_src)) : (NP'(1) << tb_src);
            rd[tb_blk] = (tb_kind != 3);
            tb_busy = 0;
         end else if (tb_busy) begin
            if (tb_kind != 2 && (ack_valid & tb_own & tb_pend) != '0) tb_data = ack_data;
            tb_pend = tb_pend & ~ack_valid;
         end
         if (st) begin
            tb_busy = 1; tb_blk = req_blk; tb_src = req_src; tb_kind = k;
            tb_pend = tgt; tb_own = tgt; tb_data = '0;
         end
      end
   end

   // ---------------------------------------------------------------
   // compare on every cycle, then model the caches' answers
   // ---------------------------------------------------------------
   int            dly [NP];
   int            cnt [NP];
   logic          rnd_dly = 1'b0;
   logic [NP-1:0] stray = '0;
   int            tag = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         chk("rsp_valid", 64'(rsp_valid), 64'(e_rsp));
         if (e_rsp) begin
            chk("rsp_dst",  64'(rsp_dst),  64'(e_rdst));
            chk("rsp_blk",  64'(rsp_blk),  64'(e_rblk));
            chk("rsp_excl", 64'(rsp_excl), 64'(e_excl));
            chk("rsp_data", 64'(rsp_data), 64'(e_rdata));
         end
         chk("nack_valid", 64'(nack_valid), 64'(e_nack));
         if (e_nack) chk("nack_dst", 64'(nack_dst), 64'(e_ndst));
         chk("cmd_valid", 64'(cmd_valid), 64'(e_cmd));
         if (e_cmd != '0) begin
            chk("cmd_kind", 64'(cmd_kind), 64'(e_kind));
            chk("cmd_blk",  64'(cmd_blk),  64'(e_cblk));
         end
      end
      for (int q = 0; q < NP; q++) begin
         ack_valid[q] = (cnt[q] == 1) || stray[q];
         if (cnt[q] == 1) begin
            tag++;
            ack_data = 32'hC0DE_0000 + (tag << 4) + q;
         end
         if (cnt[q] > 0) cnt[q]--;
         if (cmd_valid[q]) cnt[q] = rnd_dly ? int'($urandom_range(1, 5)) : dly[q];
      end
   end

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------------------------------------------------------
   // stimulus
   // ---------------------------------------------------------------
   task automatic clr();
      req_valid = 0; wb_valid = 0; stray = '0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1; clr();
      end
   endtask

   task automatic rq(int s, bit w, int b);
      @(posedge clk); #1; clr();
      req_valid = 1; req_src = PW'(s); req_write = w; req_blk = BW'(b);
   endtask

   task automatic wb(int s, int b, logic [DW-1:0] v);
      @(posedge clk); #1; clr();
      wb_valid = 1; wb_src = PW'(s); wb_blk = BW'(b); wb_data = v;
   endtask

   task automatic both(int ws, int wbk, logic [DW-1:0] v, int s, bit w, int b);
      @(posedge clk); #1; clr();
      wb_valid = 1; wb_src = PW'(ws); wb_blk = BW'(wbk); wb_data = v;
      req_valid = 1; req_src = PW'(s); req_write = w; req_blk = BW'(b);
   endtask

   task automatic set_dly(int v);
      for (int q = 0; q < NP; q++) dly[q] = v;
   endtask

   initial begin
      for (int q = 0; q < NP; q++) begin cnt[q] = 0; dly[q] = 2; end
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1: idle outputs right after reset
      chk("reset rsp_valid",  64'(rsp_valid),  64'd0);
      chk("reset nack_valid", 64'(nack_valid), 64'd0);
      chk("reset cmd_valid",  64'(cmd_valid),  64'd0);

      cur_req = "R2";
      rq(0, 0, 3); idle(2);
      rq(1, 0, 3); idle(2);

      cur_req = "R11";   // also R4: invalidate two sharers, late acks
      set_dly(8);
      rq(2, 1, 3);
      @(posedge clk); #1; clr(); stray = 4'b1000;
      cur_req = "R10";
      rq(3, 0, 3);       // busy block: NACK
      rq(3, 0, 5);       // other block, no messages: served
      rq(3, 1, 6);       // other block, exclusive at once
      idle(1);
      rq(0, 0, 6);       // would need a recall while busy: NACK
      idle(12);

      set_dly(2);
      cur_req = "R6";
      rq(0, 1, 3); idle(8);
      cur_req = "R3";
      rq(1, 0, 3); idle(8);
      cur_req = "R7";
      rq(3, 0, 6); idle(2);
      cur_req = "R8";
      wb(3, 6, 32'h1234_5678); idle(1);
      rq(1, 0, 6); idle(2);
      cur_req = "R9";
      wb(0, 6, 32'hDEAD_0001); idle(1);
      wb(1, 3, 32'hDEAD_0002); idle(1);
      rq(2, 1, 6); idle(8);
      rq(3, 0, 3); idle(8);
      cur_req = "R5";
      rq(0, 1, 9); idle(2);
      cur_req = "R12";
      both(0, 9, 32'h5555_0009, 1, 0, 9); idle(1);
      rq(1, 0, 9); idle(2);
      rq(1, 1, 10); idle(2);
      both(1, 10, 32'h6666_000A, 2, 0, 11); idle(1);
      rq(2, 0, 10); idle(2);

      cur_req = "R10";   // mixed traffic on four blocks
      rnd_dly = 1;
      for (int i = 0; i < 1500; i++) begin
         @(posedge clk); #1; clr();
         if ($urandom_range(0, 1) == 1) begin
            req_valid = 1; req_src = PW'($urandom_range(0, NP-1));
            req_write = 1'($urandom_range(0, 1)); req_blk = BW'($urandom_range(0, 3));
         end
         if ($urandom_range(0, 3) == 0) begin
            int b;
            b = $urandom_range(0, 3);
            wb_valid = 1; wb_blk = BW'(b); wb_data = $urandom;
            wb_src = PW'($urandom_range(0, NP-1));
            if (rd[b] && $urandom_range(0, 2) != 0)
               for (int q = 0; q < NP; q++) if (rp[b][q]) wb_src = PW'(q);
         end
         if ($urandom_range(0, 7) == 0) stray = NP'($urandom_range(1, 15));
      end
      idle(20);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule